// File: doc/BRIEF.md
# Single-Operand ALU with Condition Codes

This unit performs the one-operand arithmetic, logical, shift and rotate operations of a 16-bit minicomputer datapath. It works on a full word or on a byte. An upstream sequencer that has already fetched the operand presents four inputs together with a one-cycle strobe: a 6-bit operation selector, a byte/word flag, the operand and the current N, Z, V, C condition codes. On the next cycle the unit returns the result, the updated condition codes and a write-enable that tells the sequencer whether the result must be stored back.

Three design modules sit inside the top. A selector decoder maps the selector onto an enumerated operation and works out the write-enable. A combinational compute stage produces the result and the flag rules for each operation. The top holds a two-state controller and the output registers. The controller is in ST_IDLE after reset and moves to ST_REPORT on a strobe (transition T_ACCEPT). It stays in ST_REPORT when another strobe arrives while it is reporting (T_CHAIN). It returns to ST_IDLE when no strobe arrives (T_RETIRE). The done output is high exactly while the controller is in ST_REPORT.

Top module: `sop_alu`

## Requirements
- R1: The selector codes octal 50 to 63 select, in this order: clear, complement, increment, decrement, negate, add-carry, subtract-carry, test, rotate right, rotate left, arithmetic shift right and arithmetic shift left. Octal 67 selects sign-extend. Every other code gives result 0, write-enable 0 and flags passed through unchanged.
- R2: With byte_mode=1 the result is limited to bits 7..0 (bits 15..8 are 0) and bit 7 is the sign. With byte_mode=0 bit 15 is the sign. Sign-extend is the exception and always produces a full word. The flag bus is packed as bit 3 N, bit 2 Z, bit 1 V, bit 0 C.
- R3: Clear gives result 0 and flags N=0, Z=1, V=0, C=0.
- R4: Complement gives the bitwise inverse of the operand, with C=1, V=0, and N and Z taken from the result.
- R5: Increment and decrement keep C. Increment sets V when the result is the most-negative value. Decrement sets V when the operand was the most-negative value.
- R6: Negate gives the two's complement of the operand. V=1 only when the operand is the most-negative value. C=1 when the result is nonzero.
- R7: Add-carry with C=1 adds one, sets V on a sign change from 0 to 1, and sets C when the result wraps to zero. With C=0 it passes the operand through and clears V and C.
- R8: Subtract-carry with C=1 subtracts one, sets V on a sign change from 1 to 0, and sets C when the result is all ones. With C=0 it passes the operand through and clears V and C.
- R9: Rotate right moves the old C into the sign bit and bit 0 into C. Rotate left moves the old C into bit 0 and the old sign into C. After either, V = N XOR C.
- R10: Arithmetic shift right keeps the sign bit and moves bit 0 into C. Arithmetic shift left shifts in a zero and moves the old sign into C. After either, V = N XOR C.
- R11: Test gives the masked operand as result and write-enable 0. N and Z come from the operand, and V and C are cleared.
- R12: Sign-extend gives 16'hFFFF when the incoming N is 1 and 0 otherwise. It sets Z to the inverse of N and keeps N, V and C.
- R13: Result, flags and write-enable are captured only on a cycle with in_valid high. out_done is high in the cycle after each strobe and low otherwise. With in_valid low the outputs hold. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle operation strobe |
| op_sel | input | 6 | Operation selector |
| byte_mode | input | 1 | 1 = byte operand, 0 = word operand |
| operand | input | 16 | Operand value |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| out_done | output | 1 | High in the cycle after a strobe |
| result | output | 16 | Registered result |
| flags_out | output | 4 | Registered new flags {N,Z,V,C} |
| wr_en | output | 1 | Result must be written back |

## Verification
The unit can report one result and accept the next strobe in the same cycle: this is the T_CHAIN transition, where done stays high while new operands are captured. The bench provokes it with runs of back-to-back strobes and with randomly gapped strobes. A scoreboard queue checks that each done cycle pops exactly the entry of the strobe one cycle earlier. A done without a pending entry, or entries left over at the end, counts as a miscompare.

// File: rtl/sop_pkg.sv
package sop_pkg;

    localparam int FLAG_W = 4;

    typedef enum logic [3:0] {
        OP_CLR,
        OP_COM,
        OP_INC,
        OP_DEC,
        OP_NEG,
        OP_ADC,
        OP_SBC,
        OP_TST,
        OP_ROR,
        OP_ROL,
        OP_ASR,
        OP_ASL,
        OP_SXT,
        OP_NONE
    } op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef enum logic {
        ST_IDLE,
        ST_REPORT
    } st_e;

endpackage

// File: rtl/sop_decode.sv
module sop_decode
    import sop_pkg::*;
#(
    parameter int SEL_W = 6
) (
    input  logic [SEL_W-1:0] sel,
    output op_e              op,
    output logic             writes
);

    localparam logic [SEL_W-1:0] C_CLR = SEL_W'(6'o50);
    localparam logic [SEL_W-1:0] C_COM = SEL_W'(6'o51);
    localparam logic [SEL_W-1:0] C_INC = SEL_W'(6'o52);
    localparam logic [SEL_W-1:0] C_DEC = SEL_W'(6'o53);
    localparam logic [SEL_W-1:0] C_NEG = SEL_W'(6'o54);
    localparam logic [SEL_W-1:0] C_ADC = SEL_W'(6'o55);
    localparam logic [SEL_W-1:0] C_SBC = SEL_W'(6'o56);
    localparam logic [SEL_W-1:0] C_TST = SEL_W'(6'o57);
    localparam logic [SEL_W-1:0] C_ROR = SEL_W'(6'o60);
    localparam logic [SEL_W-1:0] C_ROL = SEL_W'(6'o61);
    localparam logic [SEL_W-1:0] C_ASR = SEL_W'(6'o62);
    localparam logic [SEL_W-1:0] C_ASL = SEL_W'(6'o63);
    localparam logic [SEL_W-1:0] C_SXT = SEL_W'(6'o67);

    always_comb begin
        case (sel)
            C_CLR:   op = OP_CLR;
            C_COM:   op = OP_COM;
            C_INC:   op = OP_INC;
            C_DEC:   op = OP_DEC;
            C_NEG:   op = OP_NEG;
            C_ADC:   op = OP_ADC;
            C_SBC:   op = OP_SBC;
            C_TST:   op = OP_TST;
            C_ROR:   op = OP_ROR;
            C_ROL:   op = OP_ROL;
            C_ASR:   op = OP_ASR;
            C_ASL:   op = OP_ASL;
            C_SXT:   op = OP_SXT;
            default: op = OP_NONE;
        endcase
    end

    // Test and the unused codes never store a result.
    assign writes = (op != OP_TST) && (op != OP_NONE);

endmodule

// File: rtl/sop_compute.sv
module sop_compute
    import sop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  op_e               op,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] operand,
    input  flags_t            fin,
    output logic [DATA_W-1:0] res,
    output flags_t            fout
);

    localparam int PAD_W = DATA_W - BYTE_W;
    localparam logic [DATA_W-1:0] WORD_MASK = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] BYTE_MASK = {{PAD_W{1'b0}}, {BYTE_W{1'b1}}};
    localparam logic [DATA_W-1:0] WORD_TOP  = DATA_W'(1) << (DATA_W - 1);
    localparam logic [DATA_W-1:0] BYTE_TOP  = DATA_W'(1) << (BYTE_W - 1);

    logic [DATA_W-1:0] mask, top, a;
    logic [DATA_W-1:0] plus1, minus1, negated;
    logic              a_sign, a_is_min;
    logic              upd_nz, upd_vx;

    // Operand view for the selected width
    always_comb begin
        mask     = byte_mode ? BYTE_MASK : WORD_MASK;
        top      = byte_mode ? BYTE_TOP  : WORD_TOP;
        a        = operand & mask;
        a_sign   = |(a & top);
        a_is_min = (a == top);
        plus1    = (a + DATA_W'(1)) & mask;
        minus1   = (a - DATA_W'(1)) & mask;
        negated  = ((~a) + DATA_W'(1)) & mask;
    end

    // Per-operation result and special flags, then common N/Z and V rules
    always_comb begin
        res    = '0;
        fout   = fin;
        upd_nz = 1'b1;
        upd_vx = 1'b0;
        unique case (op)
            OP_CLR: begin
                res    = '0;
                fout.v = 1'b0;
                fout.c = 1'b0;
            end
            OP_COM: begin
                res    = (~a) & mask;
                fout.v = 1'b0;
                fout.c = 1'b1;
            end
            OP_INC: begin
                res    = plus1;
                fout.v = (plus1 == top);
            end
            OP_DEC: begin
                res    = minus1;
                fout.v = a_is_min;
            end
            OP_NEG: begin
                res    = negated;
                fout.v = a_is_min;
                fout.c = (negated != '0);
            end
            OP_ADC: begin
                if (fin.c) begin
                    res    = plus1;
                    fout.v = !a_sign && |(plus1 & top);
                    fout.c = (plus1 == '0);
                end else begin
                    res    = a;
                    fout.v = 1'b0;
                    fout.c = 1'b0;
                end
            end
            OP_SBC: begin
                if (fin.c) begin
                    res    = minus1;
                    fout.v = a_sign && !(|(minus1 & top));
                    fout.c = (minus1 == mask);
                end else begin
                    res    = a;
                    fout.v = 1'b0;
                    fout.c = 1'b0;
                end
            end
            OP_TST: begin
                res    = a;
                fout.v = 1'b0;
                fout.c = 1'b0;
            end
            OP_ROR: begin
                res    = (a >> 1) | (fin.c ? top : '0);
                fout.c = a[0];
                upd_vx = 1'b1;
            end
            OP_ROL: begin
                res    = ((a << 1) | DATA_W'(fin.c)) & mask;
                fout.c = a_sign;
                upd_vx = 1'b1;
            end
            OP_ASR: begin
                res    = (a >> 1) | (a & top);
                fout.c = a[0];
                upd_vx = 1'b1;
            end
            OP_ASL: begin
                res    = (a << 1) & mask;
                fout.c = a_sign;
                upd_vx = 1'b1;
            end
            OP_SXT: begin
                res    = fin.n ? WORD_MASK : '0;
                fout.z = !fin.n;
                upd_nz = 1'b0;
            end
            OP_NONE: begin
                res    = '0;
                upd_nz = 1'b0;
            end
            default: begin
                res    = '0;
                upd_nz = 1'b0;
            end
        endcase
        if (upd_nz) begin
            fout.n = |(res & top);
            fout.z = (res == '0);
        end
        if (upd_vx) begin
            fout.v = fout.n ^ fout.c;
        end
    end

endmodule

// File: rtl/sop_alu.sv
module sop_alu
    import sop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SEL_W-1:0]  op_sel,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] operand,
    input  logic [3:0]        flags_in,
    output logic              out_done,
    output logic [DATA_W-1:0] result,
    output logic [3:0]        flags_out,
    output logic              wr_en
);

    op_e               dec_op;
    logic              dec_wr;
    logic [DATA_W-1:0] cmp_res;
    flags_t            cmp_flags;
    st_e               state_q, state_d;

    sop_decode #(.SEL_W(SEL_W)) u_decode (
        .sel    (op_sel),
        .op     (dec_op),
        .writes (dec_wr)
    );

    sop_compute #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_compute (
        .op        (dec_op),
        .byte_mode (byte_mode),
        .operand   (operand),
        .fin       (flags_t'(flags_in)),
        .res       (cmp_res),
        .fout      (cmp_flags)
    );

    // Next state: T_ACCEPT / T_CHAIN on a strobe, T_RETIRE otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = in_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            flags_out <= '0;
            wr_en     <= 1'b0;
        end else if (in_valid) begin
            result    <= cmp_res;
            flags_out <= cmp_flags;
            wr_en     <= dec_wr;
        end
    end

    assign out_done = (state_q == ST_REPORT);

    p_done_after_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_done);
    p_no_stray_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_done);
    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flags_out) && $stable(wr_en)));
    p_clear_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == SEL_W'(6'o50)) |=> (result == '0 && flags_out == 4'b0100));
    p_test_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == SEL_W'(6'o57)) |=> (!wr_en && flags_out[1:0] == 2'b00));
    p_unused_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == SEL_W'(6'o64)) |=> (!wr_en && flags_out == $past(flags_in)));
    p_inc_keeps_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == SEL_W'(6'o52)) |=> (flags_out[0] == $past(flags_in[0])));
    p_sxt_z_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == SEL_W'(6'o67)) |=> (wr_en && flags_out[2] == !flags_out[3]));
    p_byte_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && byte_mode && op_sel != SEL_W'(6'o67))
            |=> (result[DATA_W-1:BYTE_W] == '0));

endmodule

// File: tb/sop_alu_tb_top.sv
`timescale 1ns/1ps
module sop_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  op_sel = '0;
    logic        byte_mode = 1'b0;
    logic [15:0] operand = '0;
    logic [3:0]  flags_in = '0;
    logic        out_done;
    logic [15:0] result;
    logic [3:0]  flags_out;
    logic        wr_en;

    sop_alu dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_sel    (op_sel),
        .byte_mode (byte_mode),
        .operand   (operand),
        .flags_in  (flags_in),
        .out_done  (out_done),
        .result    (result),
        .flags_out (flags_out),
        .wr_en     (wr_en)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [15:0] r;
        logic [3:0]  f;
        logic        w;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 0;

    // Reference behaviour written from the requirements; flags {N,Z,V,C}
    function automatic void ref_op(input logic [5:0] s, input logic bm,
                                   input logic [15:0] x, input logic [3:0] f,
                                   output logic [15:0] r, output logic [3:0] fo,
                                   output logic w);
        logic [15:0] m, top, a;
        logic n0, z0, v0, c0, n, z, v, c;
        m   = bm ? 16'h00FF : 16'hFFFF;
        top = bm ? 16'h0080 : 16'h8000;
        a   = x & m;
        {n0, z0, v0, c0} = f;
        n = n0; z = z0; v = v0; c = c0;
        r = 16'h0000;
        w = 1'b1;
        case (s)
            6'o50: begin r = 0; v = 0; c = 0; end
            6'o51: begin r = ~a & m; v = 0; c = 1; end
            6'o52: begin r = (a + 16'd1) & m; v = (r == top); end
            6'o53: begin r = (a - 16'd1) & m; v = (a == top); end
            6'o54: begin r = (16'd0 - a) & m; v = (a == top); c = (r != 0); end
            6'o55: if (c0) begin r = (a + 16'd1) & m; v = (r == top); c = (r == 0); end
                   else begin r = a; v = 0; c = 0; end
            6'o56: if (c0) begin r = (a - 16'd1) & m; v = (a == top); c = (r == m); end
                   else begin r = a; v = 0; c = 0; end
            6'o57: begin r = a; v = 0; c = 0; w = 0; end
            6'o60: begin r = (a >> 1) | (c0 ? top : 16'h0); c = a[0]; end
            6'o61: begin r = ((a << 1) | {15'h0, c0}) & m; c = ((a & top) != 0); end
            6'o62: begin r = (a >> 1) | (a & top); c = a[0]; end
            6'o63: begin r = (a << 1) & m; c = ((a & top) != 0); end
            6'o67: begin r = n0 ? 16'hFFFF : 16'h0000; z = !n0; end
            default: begin r = 16'h0000; w = 0; end
        endcase
        if (s >= 6'o50 && s <= 6'o63) begin
            n = ((r & top) != 0);
            z = (r == 0);
        end
        if (s >= 6'o60 && s <= 6'o63) v = n ^ c;
        fo = {n, z, v, c};
    endfunction

    task automatic apply(input logic [5:0] s, input logic bm, input logic [15:0] x,
                         input logic [3:0] f, input string tag);
        exp_t e;
        ref_op(s, bm, x, f, e.r, e.f, e.w);
        e.tag = tag;
        sb_q.push_back(e);
        op_sel = s; byte_mode = bm; operand = x; flags_in = f;
        in_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: pops one expected entry per done cycle
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && out_done && !finished) begin
            n_chk++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL R13 done without pending strobe: actual done=1 expected done=0");
            end else begin
                e = sb_q.pop_front();
                if (result !== e.r || flags_out !== e.f || wr_en !== e.w) begin
                    n_bad++;
                    $display("FAIL %s sel=%o: actual r=%h f=%b w=%b expected r=%h f=%b w=%b",
                             e.tag, op_sel, result, flags_out, wr_en, e.r, e.f, e.w);
                end
            end
        end
    end

    // R13: with in_valid low, new inputs must not reach the outputs
    task automatic check_hold();
        logic [15:0] r0;
        logic [3:0]  f0;
        logic        w0;
        idle(); idle();
        r0 = result; f0 = flags_out; w0 = wr_en;
        op_sel = 6'o51; byte_mode = 1'b0; operand = ~r0; flags_in = ~f0;
        idle(); idle();
        n_chk++;
        if (result !== r0 || flags_out !== f0 || wr_en !== w0 || out_done !== 1'b0) begin
            n_bad++;
            $display("FAIL R13 hold: actual r=%h f=%b w=%b d=%b expected r=%h f=%b w=%b d=0",
                     result, flags_out, wr_en, out_done, r0, f0, w0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL R13 watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (4) @(negedge clk);
        n_chk++;
        if (out_done !== 0 || result !== 0 || flags_out !== 0 || wr_en !== 0) begin
            n_bad++;
            $display("FAIL R13 reset: actual d=%b r=%h f=%b w=%b expected all zero",
                     out_done, result, flags_out, wr_en);
        end
        rst_n = 1'b1;
        idle();

        apply(6'o50, 0, 16'h1234, 4'b1011, "R3");
        apply(6'o50, 1, 16'hFFFF, 4'b1001, "R3");
        apply(6'o51, 0, 16'h00FF, 4'b0000, "R4");
        apply(6'o51, 1, 16'h12FF, 4'b1010, "R4");
        apply(6'o52, 0, 16'h7FFF, 4'b0000, "R5");
        apply(6'o52, 1, 16'h007F, 4'b0001, "R5");
        apply(6'o52, 0, 16'hFFFF, 4'b0001, "R5");
        apply(6'o53, 0, 16'h8000, 4'b0001, "R5");
        apply(6'o53, 1, 16'h0000, 4'b0000, "R5");
        apply(6'o54, 0, 16'h8000, 4'b0000, "R6");
        apply(6'o54, 0, 16'h0000, 4'b1111, "R6");
        apply(6'o54, 1, 16'h0001, 4'b0000, "R6");
        apply(6'o55, 0, 16'h7FFF, 4'b0001, "R7");
        apply(6'o55, 0, 16'hFFFF, 4'b0001, "R7");
        apply(6'o55, 0, 16'h1234, 4'b0010, "R7");
        apply(6'o56, 0, 16'h8000, 4'b0001, "R8");
        apply(6'o56, 0, 16'h0000, 4'b0001, "R8");
        apply(6'o56, 1, 16'h0080, 4'b0010, "R8");
        apply(6'o60, 0, 16'h0001, 4'b0001, "R9");
        apply(6'o61, 1, 16'h0080, 4'b0000, "R9");
        apply(6'o62, 0, 16'h8001, 4'b0000, "R10");
        apply(6'o63, 0, 16'h4000, 4'b0000, "R10");
        apply(6'o62, 1, 16'h0081, 4'b0000, "R10");
        apply(6'o57, 0, 16'h0000, 4'b1111, "R11");
        apply(6'o57, 1, 16'hFF80, 4'b0011, "R11");
        apply(6'o67, 1, 16'h0012, 4'b1011, "R12");
        apply(6'o67, 0, 16'hFFFF, 4'b0111, "R12");
        apply(6'o52, 1, 16'hAB80, 4'b0000, "R2");
        apply(6'o64, 0, 16'h5555, 4'b1010, "R1");
        apply(6'o00, 0, 16'h5555, 4'b0101, "R1");
        apply(6'o77, 1, 16'hAAAA, 4'b1111, "R1");
        check_hold();

        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            apply((lfsr[2]) ? (6'o50 + 6'(lfsr[6:3] % 4'd14)) : lfsr[8:3],
                  lfsr[9], {lfsr[7:0], lfsr[15:8]}, lfsr[13:10], "R1");
            if (lfsr[0] && lfsr[5]) idle();
        end
        check_hold();
        idle(); idle();

        n_chk++;
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R13 pending strobes: actual %0d expected 0", sb_q.size());
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule